// File: doc/BRIEF.md
# Bidirectional Signed-Count Logical Shifter

This block is a purely combinational logical shift unit for a DSP datapath. It takes an operand, a count half-word and a mode select, and returns the shifted operand. The sign of the count sets the direction. A positive count moves bits toward the MSB and a negative count moves them toward the LSB. Vacated positions always take zeros, even when the operand's top bit is set.

Four operand layouts are supported:
- a single 16-bit half chosen from the operand;
- a 32-bit word shifted as one value;
- a pair of 16-bit lanes that shift by the same count but never exchange bits;
- a 40-bit accumulator.

The result changes in the same cycle as the inputs. It carries no state.

Top module: `lsh_top`

## Requirements
- R1: The count is `count_hw[5:0]` read as a 6-bit two's-complement number (range -32 to +31). Bits `count_hw[15:6]` have no effect on the result.
- R2: A positive count n shifts the lane left by n. Zeros fill the low n bits, and bits moved past the lane MSB are lost (16-bit 0xC00F by +1 gives 0x801E; 32-bit 0x30000003 by +2 gives 0xC000000C).
- R3: A negative count -n shifts the lane right by n, with zeros entering at the MSB whatever the sign bit (16-bit 0x80F0 by -1 gives 0x4078; 32-bit 0x80F080F0 by -3 gives 0x101E101E).
- R4: A shift magnitude equal to or larger than the lane width gives an all-zero lane. The lane widths are 16 in half and vector modes, 32 in word mode and 40 in accumulator mode.
- R5: A count of zero returns the mode's source bits unchanged in the mode's output layout.
- R6: Mode 2'b00 (half) shifts `operand[31:16]` when `hi_sel`=1 and `operand[15:0]` when `hi_sel`=0. The 16-bit result is on `result[15:0]`, and `result[39:16]` is zero.
- R7: Mode 2'b01 (word) shifts `operand[31:0]` as one value, so bits cross bit 15/16 (0xC80FE00F by +4 gives 0x80FE00F0). `result[39:32]` is zero, and `operand[39:32]` has no effect.
- R8: Mode 2'b10 (vector) shifts `operand[31:16]` and `operand[15:0]` separately by the same count, with no bit crossing between lanes (0x10001000 by -2 gives 0x04000400). `result[39:32]` is zero.
- R9: Mode 2'b11 (accumulator) shifts all 40 bits of `operand` as one value into `result[39:0]`. The word read back from it is `result[31:0]`.
- R10: `hi_sel` has no effect in modes other than 2'b00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| operand | input | 40 | Data to shift; the low 32 bits are the word, the full 40 bits the accumulator |
| count_hw | input | 16 | Count half-word; only the low 6 bits are used, as a signed value |
| mode | input | 2 | 00 half, 01 word, 10 vector, 11 accumulator |
| hi_sel | input | 1 | In half mode, 1 selects the upper source half, 0 the lower |
| result | output | 40 | Shifted value, zero-extended above the active width |

## Verification
The assertions check four rules on every input change:
- the zero-filled low bits after a left shift and the cleared top bits after a right shift, in each lane shifter;
- pass-through at count zero, and the all-zero lane at an out-of-range magnitude;
- the zero upper bits of the half and word layouts;
- the empty lane-boundary bits in vector mode.

Only the bench's sweeps can show that each shifted value is arithmetically right for every count from -32 to +31. The same holds for the source-half choice, and for the unused count bits and `hi_sel` having no effect.

// File: rtl/lsh_pkg.sv
package lsh_pkg;
    localparam int HALF_W = 16;
    localparam int WORD_W = 32;
    localparam int ACC_W  = 40;
    localparam int CNT_W  = 6;
    localparam int NLANE  = WORD_W / HALF_W;

    typedef enum logic [1:0] {
        MODE_HALF = 2'b00,
        MODE_WORD = 2'b01,
        MODE_VEC  = 2'b10,
        MODE_ACC  = 2'b11
    } shift_mode_e;

    typedef struct packed {
        logic [ACC_W-1:0] value;
    } shift_res_t;
endpackage

// File: rtl/lsh_lane.sv
module lsh_lane #(
    parameter int W  = 16,
    parameter int CW = 6
) (
    input  logic [W-1:0]  din,
    input  logic [CW-1:0] cnt,
    output logic [W-1:0]  dout
);
    localparam int MAGW = CW + 1;

    logic            neg_d;
    logic [MAGW-1:0] mag_d;
    logic [W-1:0]    dout_d;
    logic [W-1:0]    low_mask_d;
    logic [W-1:0]    high_mask_d;

    always_comb begin
        neg_d = cnt[CW-1];
        mag_d = neg_d ? (MAGW'(0) - {cnt[CW-1], cnt}) : {1'b0, cnt};
        if (int'(mag_d) >= W)
            dout_d = '0;
        else if (neg_d)
            dout_d = din >> mag_d;
        else
            dout_d = din << mag_d;
    end

    assign dout = dout_d;

    // masks of the bit positions a shift must have emptied
    always_comb begin
        low_mask_d  = '0;
        high_mask_d = '0;
        for (int i = 0; i < W; i++) begin
            if (i < int'(mag_d))
                low_mask_d[i] = 1'b1;
            if (i >= W - int'(mag_d))
                high_mask_d[i] = 1'b1;
        end
    end

    always_comb begin
        if (!neg_d)
            assert_left_zero_fill_R2: assert ((dout & low_mask_d) == '0);
        if (neg_d)
            assert_right_zero_fill_R3: assert ((dout & high_mask_d) == '0);
        if (int'(mag_d) >= W)
            assert_range_zero_R4: assert (dout == '0);
        if (cnt == '0)
            assert_zero_count_pass_R5: assert (dout == din);
    end
endmodule

// File: rtl/lsh_top.sv
module lsh_top
    import lsh_pkg::*;
(
    input  logic [ACC_W-1:0]  operand,
    input  logic [HALF_W-1:0] count_hw,
    input  logic [1:0]        mode,
    input  logic              hi_sel,
    output logic [ACC_W-1:0]  result
);
    logic [CNT_W-1:0]  cnt;
    logic [HALF_W-1:0] half_src;
    logic [HALF_W-1:0] half_out;
    logic [WORD_W-1:0] word_out;
    logic [WORD_W-1:0] vec_out;
    logic [ACC_W-1:0]  acc_out;
    shift_res_t        res_d;
    shift_mode_e       mode_e;
    logic              unused_cnt_hi;

    // R1: only the low signed field of the count half-word is used
    assign cnt           = count_hw[CNT_W-1:0];
    assign unused_cnt_hi = ^count_hw[HALF_W-1:CNT_W];
    assign mode_e        = shift_mode_e'(mode);
    assign half_src      = hi_sel ? operand[WORD_W-1:HALF_W] : operand[HALF_W-1:0];

    lsh_lane #(.W(HALF_W), .CW(CNT_W)) half_i (
        .din(half_src), .cnt(cnt), .dout(half_out)
    );

    lsh_lane #(.W(WORD_W), .CW(CNT_W)) word_i (
        .din(operand[WORD_W-1:0]), .cnt(cnt), .dout(word_out)
    );

    generate
        for (genvar g = 0; g < NLANE; g++) begin : g_vec
            lsh_lane #(.W(HALF_W), .CW(CNT_W)) lane_i (
                .din (operand[g*HALF_W +: HALF_W]),
                .cnt (cnt),
                .dout(vec_out[g*HALF_W +: HALF_W])
            );
        end
    endgenerate

    lsh_lane #(.W(ACC_W), .CW(CNT_W)) acc_i (
        .din(operand), .cnt(cnt), .dout(acc_out)
    );

    always_comb begin
        res_d.value = '0;
        unique case (mode_e)
            MODE_HALF: res_d.value = {{(ACC_W-HALF_W){1'b0}}, half_out};
            MODE_WORD: res_d.value = {{(ACC_W-WORD_W){1'b0}}, word_out};
            MODE_VEC:  res_d.value = {{(ACC_W-WORD_W){1'b0}}, vec_out};
            MODE_ACC:  res_d.value = acc_out;
            default:   res_d.value = '0;
        endcase
    end

    assign result = res_d.value;

    always_comb begin
        if (mode_e == MODE_HALF)
            assert_half_upper_zero_R6: assert (result[ACC_W-1:HALF_W] == '0);
        if (mode_e == MODE_HALF && cnt == '0)
            assert_half_select_R6: assert (result[HALF_W-1:0] ==
                (hi_sel ? operand[WORD_W-1:HALF_W] : operand[HALF_W-1:0]));
        if (mode_e == MODE_WORD || mode_e == MODE_VEC)
            assert_word_upper_zero_R7: assert (result[ACC_W-1:WORD_W] == '0);
        if (mode_e == MODE_VEC && cnt[CNT_W-1])
            assert_vec_no_cross_right_R8: assert (result[HALF_W-1] == 1'b0 && result[WORD_W-1] == 1'b0);
        if (mode_e == MODE_VEC && !cnt[CNT_W-1] && cnt != '0)
            assert_vec_no_cross_left_R8: assert (result[HALF_W] == 1'b0 && result[0] == 1'b0);
        if (mode_e == MODE_ACC && cnt == '0)
            assert_acc_pass_R9: assert (result == operand);
    end
endmodule

// File: tb/lsh_top_tb_top.sv
module lsh_top_tb_top;
    logic        clk = 1'b0;
    logic [39:0] operand = '0;
    logic [15:0] count_hw = '0;
    logic [1:0]  mode = '0;
    logic        hi_sel = 1'b0;
    logic [39:0] result;
    int          n_run = 0;
    int          n_fail = 0;
    bit          finished = 1'b0;

    always #2.5 clk = ~clk;

    lsh_top dut_i (
        .operand(operand), .count_hw(count_hw), .mode(mode),
        .hi_sel(hi_sel), .result(result)
    );

    function automatic longint unsigned lane_shift(longint unsigned v, int w, int n);
        longint unsigned modv = 64'd1 << w;
        if (n >= 0) begin
            if (n >= w) return 0;
            return (v * (64'd1 << n)) % modv;
        end
        if (-n >= w) return 0;
        return (v % modv) / (64'd1 << (-n));
    endfunction

    function automatic logic [39:0] model(logic [39:0] op, logic [15:0] c, logic [1:0] m, logic hs);
        int n;
        longint unsigned r;
        n = c[5] ? int'(c[5:0]) - 64 : int'(c[5:0]);
        case (m)
            2'b00: r = lane_shift(hs ? longint'(op[31:16]) : longint'(op[15:0]), 16, n);
            2'b01: r = lane_shift(longint'(op[31:0]), 32, n);
            2'b10: r = (lane_shift(longint'(op[31:16]), 16, n) * 65536)
                       + lane_shift(longint'(op[15:0]), 16, n);
            default: r = lane_shift(longint'(op), 40, n);
        endcase
        return r[39:0];
    endfunction

    task automatic apply(input logic [39:0] op, input logic [15:0] c,
                         input logic [1:0] m, input logic hs);
        @(posedge clk);
        operand = op; count_hw = c; mode = m; hi_sel = hs;
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [39:0] exp);
        n_run++;
        if (result !== exp) begin
            n_fail++;
            $display("FAIL %s: op=%h cnt=%h mode=%0d hs=%0d got %h expected %h",
                     req, operand, count_hw, mode, hi_sel, result, exp);
        end
    endtask

    task automatic run_one(input string req, input logic [39:0] op, input logic [15:0] c,
                           input logic [1:0] m, input logic hs);
        apply(op, c, m, hs);
        check(req, model(op, c, m, hs));
    endtask

    initial begin
        logic [39:0] pats [12];
        logic [39:0] lfsr;
        pats[0] = 40'h00_0001_0001; pats[1] = 40'h00_8000_8000;
        pats[2] = 40'hFF_FFFF_FFFF; pats[3] = 40'h00_80F0_80F0;
        pats[4] = 40'h5A_C80F_E00F; pats[5] = 40'h80_3000_0003;
        pats[6] = 40'h01_1000_1000; pats[7] = 40'hA5_5A5A_A5A5;
        pats[8] = 40'h7F_0000_0000; pats[9] = 40'h00_0000_0000;
        pats[10] = 40'hC3_F80F_E00F; pats[11] = 40'h12_3456_789A;

        // reset / idle state: all-zero inputs give zero
        #1;
        n_run++;
        if (result !== 40'h0) begin
            n_fail++;
            $display("FAIL R5: idle result got %h expected %h", result, 40'h0);
        end

        // worked examples
        apply(40'h0, 16'hFFFF, 2'b00, 1'b0); apply(40'h0000_80F0, 16'hFFFF, 2'b00, 1'b0);
        check("R3", 40'h4078);
        apply(40'h80F0_80F0, 16'hFFFD, 2'b01, 1'b0); check("R3", 40'h101E_101E);
        apply(40'h0000_C00F, 16'h0001, 2'b00, 1'b0); check("R2", 40'h801E);
        apply(40'h3000_0003, 16'h0002, 2'b01, 1'b0); check("R2", 40'hC000_000C);
        apply(40'hC80F_E00F, 16'h0004, 2'b01, 1'b0); check("R7", 40'h80FE_00F0);
        apply(40'h1000_1000, 16'hFFFE, 2'b10, 1'b0); check("R8", 40'h0400_0400);
        apply(40'hC00F_800F, 16'h0001, 2'b10, 1'b0); check("R8", 40'h801E_001E);
        apply(40'hC00F_800F, 16'h0001, 2'b00, 1'b1); check("R6", 40'h801E);
        apply(40'h0001_0001, 16'h0003, 2'b11, 1'b0); check("R9", 40'h00_0008_0008);
        apply(40'hFF_0000_0000, 16'hFFE0, 2'b11, 1'b0); check("R9", 40'h00_0000_00FF);
        // R1: high count bits ignored (0xFFC1 -> +1, 0x0041 -> +1)
        apply(40'h0000_0003, 16'hFFC1, 2'b01, 1'b0); check("R1", 40'h6);
        apply(40'h0000_0003, 16'h0041, 2'b01, 1'b0); check("R1", 40'h6);
        // R4: magnitude at lane width clears the lane
        apply(40'h0000_FFFF, 16'h0010, 2'b00, 1'b0); check("R4", 40'h0);
        apply(40'hFFFF_FFFF, 16'hFFE0, 2'b01, 1'b0); check("R4", 40'h0);
        apply(40'hFFFF_FFFF, 16'hFFF0, 2'b10, 1'b0); check("R4", 40'h0);
        // R7: accumulator guard bits ignored in word mode
        apply(40'hFF_0000_0001, 16'h0000, 2'b01, 1'b0); check("R7", 40'h1);
        // R10: hi_sel ignored outside half mode
        apply(40'h12_3456_789A, 16'h0004, 2'b01, 1'b1); check("R10", 40'h4567_89A0);
        apply(40'h12_3456_789A, 16'hFFFC, 2'b10, 1'b1); check("R10", 40'h0345_0789);
        apply(40'h12_3456_789A, 16'h0000, 2'b11, 1'b1); check("R10", 40'h12_3456_789A);

        // sweeps: every mode, count, pattern and half select
        for (int m = 0; m < 4; m++)
            for (int c = -32; c < 32; c++)
                for (int p = 0; p < 12; p++)
                    for (int h = 0; h < 2; h++)
                        run_one(m == 0 ? "R6" : (m == 1 ? "R7" : (m == 2 ? "R8" : "R9")),
                                pats[p], 16'(c), 2'(m), 1'(h));

        // pseudo-random operands and counts with random upper count bits (R1, R2, R3)
        lfsr = 40'hACE1_2345_67;
        for (int i = 0; i < 2000; i++) begin
            lfsr = {lfsr[38:0], lfsr[39] ^ lfsr[37] ^ lfsr[20] ^ lfsr[18]};
            run_one(lfsr[6] ? "R3" : "R2", lfsr, {lfsr[25:16], lfsr[5:0]},
                    lfsr[9:8], lfsr[12]);
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #900000;
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule